// File: doc/BRIEF.md
# Instruction Single-Step Controller

This block lets software on a Z80-style processor bus be executed one instruction at a time without stopping the system clock. It watches the bus control strobes for an opcode fetch, which is M1, MREQ and RD all active low together. When stepping is switched on, it pulls the active-low WAIT line at each new fetch and keeps it there, so the processor stretches that fetch for as long as needed.

A debounced pushbutton releases WAIT. Each press lets exactly one instruction run: the fetch completes, the remaining machine cycles of that instruction run unhindered, and WAIT is applied again at the next fetch. A slide switch turns the feature on and off. With the switch off, the block never adds a wait state. Turning the switch on takes effect only at the start of a later fetch. Turning it off releases a held bus at once.

The bus strobes are taken as synchronous to the controller clock. The switch and the button are asynchronous and pass through synchronizers.

Top module: `single_step_ctrl`

## Requirements
- R1: After reset, `wait_no` is high, meaning no wait is requested.
- R2: While stepping is disabled (`step_en_i` low), `wait_no` stays high for every combination of `m1_ni`, `mreq_ni` and `rd_ni`.
- R3: While stepping is enabled and the bus is running, `wait_no` goes low one clock edge after the first cycle in which `m1_ni`, `mreq_ni` and `rd_ni` are all low. The other seven combinations of these strobes do not lower it.
- R4: Once low, `wait_no` stays low for as long as stepping stays enabled and no step press arrives.
- R5: A press of `step_btn_i` (high means pressed) held for at least DEB_CYCLES+2 clocks raises `wait_no` exactly DEB_CYCLES+3 edges after the press begins. Memory cycles with `m1_ni` high do not lower it again. The next fetch lowers it again.
- R6: A button pulse shorter than DEB_CYCLES clocks has no effect, so a held bus stays held.
- R7: A press yields one step however long it is held. If the button is still down at the next fetch, that fetch is held. Releasing the button later does not step.
- R8: Clearing `step_en_i` while the bus is held raises `wait_no` three edges later. It is still low two edges later.
- R9: Setting `step_en_i` while a fetch is already in progress does not lower `wait_no`. The next fetch start does lower it.
- R10: A press made after a step has released the bus, but before the next fetch, is ignored. The next fetch is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, runs continuously |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Slide switch, high enables stepping (asynchronous) |
| step_btn_i | input | 1 | Step pushbutton, high when pressed (asynchronous, bouncing) |
| m1_ni | input | 1 | Bus M1 strobe, active low |
| mreq_ni | input | 1 | Bus memory request strobe, active low |
| rd_ni | input | 1 | Bus read strobe, active low |
| wait_no | output | 1 | Bus WAIT request, active low |

## Verification
The fetch strobes reach WAIT through one register, so the bench drives them half a cycle before an edge and samples WAIT at the falling edge after that one edge. A switch change crosses two synchronizer stages and the state register, so the bench checks at two edges (unchanged) and at three edges (changed). A press crosses the synchronizer, a DEB_CYCLES-long debounce count and the state register. Release is checked as still held after DEB_CYCLES+2 edges and as released after DEB_CYCLES+3 edges. Strobe sweeps cover all eight combinations, with stepping both on and off.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,  // running, no hold armed
    ST_HELD = 2'd1,  // fetch stretched by WAIT
    ST_STEP = 2'd2   // released for one instruction
  } step_state_e;

  typedef struct packed {
    logic m1_n;
    logic mreq_n;
    logic rd_n;
  } bus_ctl_t;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe[0] <= '0;
    else         pipe[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe[i] <= '0;
      else         pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/ss_debounce.sv
module ss_debounce #(
  parameter int CYCLES = 1_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,    // already synchronized
  output logic press_o   // one-cycle pulse per accepted press
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;
  logic             settle;

  assign settle = (raw_i != stable_q) && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
      press_o  <= 1'b0;
    end else begin
      press_o <= settle && raw_i;
      if (raw_i == stable_q) begin
        cnt_q <= '0;
      end else if (settle) begin
        cnt_q    <= '0;
        stable_q <= raw_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ss_fetch_det.sv
module ss_fetch_det
  import ss_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_ctl_t bus_i,
  output logic     fetch_o,
  output logic     fetch_start_o
);
  logic fetch_q;

  // opcode fetch: M1, MREQ and RD all active
  assign fetch_o = ~bus_i.m1_n & ~bus_i.mreq_n & ~bus_i.rd_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fetch_q <= 1'b0;
    else         fetch_q <= fetch_o;
  end

  assign fetch_start_o = fetch_o & ~fetch_q;
endmodule

// File: rtl/ss_wait_fsm.sv
module ss_wait_fsm
  import ss_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        fetch_start_i,
  input  logic        step_i,
  output logic        hold_o,
  output step_state_e state_o
);
  step_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FREE: if (en_i && fetch_start_i) state_d = ST_HELD;
      ST_HELD: begin
        if (!en_i)       state_d = ST_FREE;
        else if (step_i) state_d = ST_STEP;
      end
      ST_STEP: begin
        if (!en_i)              state_d = ST_FREE;
        else if (fetch_start_i) state_d = ST_HELD;
      end
      default: state_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FREE;
    else         state_q <= state_d;
  end

  assign hold_o  = (state_q == ST_HELD);
  assign state_o = state_q;
endmodule

// File: rtl/single_step_ctrl.sv
module single_step_ctrl
  import ss_pkg::*;
#(
  parameter int DEB_CYCLES  = 1_250_000,  // ~10 ms at 125 MHz
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_en_i,
  input  logic step_btn_i,
  input  logic m1_ni,
  input  logic mreq_ni,
  input  logic rd_ni,
  output logic wait_no
);
  localparam int N_ASYNC = 2;

  logic [N_ASYNC-1:0] async_raw, async_s;
  logic               en_s, btn_s;
  logic               fetch, fetch_start, step_pulse, hold;
  bus_ctl_t           bus;
  step_state_e        state;

  assign async_raw = {step_btn_i, step_en_i};
  assign en_s      = async_s[0];
  assign btn_s     = async_s[1];
  assign bus       = '{m1_n: m1_ni, mreq_n: mreq_ni, rd_n: rd_ni};

  ss_sync #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_raw),
    .q_o   (async_s)
  );

  ss_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (btn_s),
    .press_o(step_pulse)
  );

  ss_fetch_det u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_i        (bus),
    .fetch_o      (fetch),
    .fetch_start_o(fetch_start)
  );

  ss_wait_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_s),
    .fetch_start_i(fetch_start),
    .step_i       (step_pulse),
    .hold_o       (hold),
    .state_o      (state)
  );

  assign wait_no = ~hold;
endmodule

// File: rtl/ss_checker.sv
module ss_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_s_i,
  input logic fetch_start_i,
  input logic step_i,
  input logic wait_ni
);
  p_quiet_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s_i |=> wait_ni);

  p_hold_on_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_ni) |-> $past(fetch_start_i));

  p_hold_persists_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s_i && !wait_ni && !step_i) |=> !wait_ni);

  p_step_releases_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s_i && !wait_ni && step_i) |=> wait_ni);

  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !step_i);

  p_no_midcycle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_ni && !fetch_start_i) |=> wait_ni);
endmodule

bind single_step_ctrl ss_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_s_i       (en_s),
  .fetch_start_i(fetch_start),
  .step_i       (step_pulse),
  .wait_ni      (wait_no)
);

// File: tb/tb_single_step_ctrl.sv
module tb_single_step_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, btn = 1'b0;
  logic m1_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1;
  logic wait_n;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  single_step_ctrl #(.DEB_CYCLES(N), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .step_en_i(en), .step_btn_i(btn),
    .m1_ni(m1_n), .mreq_ni(mreq_n), .rd_ni(rd_n), .wait_no(wait_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string req);
    n_chk++;
    if (wait_n !== exp) begin
      n_bad++;
      $display("FAIL %s: wait_no=%b expected %b at %0t", req, wait_n, exp, $time);
    end
  endtask

  task automatic bus(input logic [2:0] c);  // {m1_n, mreq_n, rd_n}
    {m1_n, mreq_n, rd_n} = c;
  endtask

  task automatic press_full();  // press released after step, then settle
    btn = 1'b1;
    tick(N + 4);
    btn = 1'b0;
    tick(N + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(1'b1, "R1 reset");

    // R2: all strobe combinations while disabled
    for (int c = 0; c < 8; c++) begin
      bus(3'(c)); tick(2); chk(1'b1, "R2 disabled sweep");
      bus(3'b111); tick(1);
    end

    en = 1'b1; tick(4);
    chk(1'b1, "R9 enable alone");

    // R3/R4/R8: strobe sweep while enabled
    for (int c = 0; c < 8; c++) begin
      bus(3'(c)); tick(1);
      chk((c == 0) ? 1'b0 : 1'b1, "R3 enabled sweep");
      if (c == 0) begin
        tick(6); chk(1'b0, "R4 held");
        en = 1'b0; tick(2); chk(1'b0, "R8 before release");
        tick(1); chk(1'b1, "R8 released");
        bus(3'b111); tick(1);
        en = 1'b1; tick(4);
      end else begin
        bus(3'b111); tick(1);
      end
    end

    // R5: one instruction per press
    bus(3'b000); tick(1); chk(1'b0, "R5 fetch held");
    btn = 1'b1;
    tick(N + 2); chk(1'b0, "R5 before debounce");
    tick(1);     chk(1'b1, "R5 released");
    btn = 1'b0; tick(N + 4);
    bus(3'b111); tick(1);
    bus(3'b100); tick(2); chk(1'b1, "R5 memory read");
    bus(3'b111); tick(1);
    bus(3'b101); tick(2); chk(1'b1, "R5 memory write");
    bus(3'b111); tick(1);
    bus(3'b000); tick(1); chk(1'b0, "R5 next fetch held");

    // R6: short glitch ignored
    btn = 1'b1; tick(N - 3);
    btn = 1'b0; tick(N + 4);
    chk(1'b0, "R6 glitch ignored");

    // R7: long press yields one step
    btn = 1'b1; tick(N + 3);
    chk(1'b1, "R7 released");
    bus(3'b111); tick(1);
    bus(3'b100); tick(2);
    bus(3'b111); tick(1);
    bus(3'b000); tick(1); chk(1'b0, "R7 next fetch held");
    tick(N + 4); chk(1'b0, "R7 still held with button down");
    btn = 1'b0; tick(N + 4); chk(1'b0, "R7 button release no step");

    // R10: extra press between step and next fetch ignored
    press_full(); chk(1'b1, "R10 first step");
    bus(3'b111); tick(1);
    press_full(); chk(1'b1, "R10 still running");
    bus(3'b000); tick(1); chk(1'b0, "R10 next fetch held");

    // R9: enable during an active fetch
    en = 1'b0; tick(3); chk(1'b1, "R8 disable");
    bus(3'b111); tick(1);
    bus(3'b000); tick(1); chk(1'b1, "R2 fetch while off");
    en = 1'b1; tick(5); chk(1'b1, "R9 mid-fetch enable");
    bus(3'b111); tick(1);
    bus(3'b000); tick(1); chk(1'b0, "R9 next fetch held");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule